// File: doc/BRIEF.md
# Multiplexed Slow-Port Write Controller

This block turns a single host write request (a 24-bit address plus a 16-bit data word) into a complete write access on a narrow external port. The port has only eight shared address/data lines. The controller first sends the five bytes out one per cycle. Address bytes are qualified by an address-latch enable pulse and data bytes by a capture pulse, so that external latches rebuild the wide address and data words. It then runs a microprocessor-style write cycle on those latched values. That cycle uses an active-low chip select, an active-low address strobe, a read/write select held low for writing, and an active-low data-transfer acknowledge returned by the peripheral.

Each access is shaped by three 4-bit timing counts, all in port clock cycles: setup, pulse window and hold. The counts, the address and the data are captured when the request is granted. One idle cycle comes between the byte transfer and the setup phase, and another comes after the hold phase. A single turnaround cycle closes the access. Only the microprocessor strobe style (protocol mode value 1) is carried out; requests made under any other mode value are refused. When the peripheral never acknowledges within the pulse window, the strobe is still released when the window ends, and an error flag is raised.

Top module: `sp_write_ctrl`

## Requirements
- R1: While rst_ni is low and after its release: busy_o=0, err_o=0, cs_no=1, ads_no=1, rw_o=1, bus_oe_no=1, bus_dir_o=0, bus_ale_o=0, bus_cap_o=0, bus_ad_o=0.
- R2: gnt_o is 1 exactly when req_i=1, the port is idle and mode_i=1. The request is taken at that clock edge, and busy_o is then 1 for every cycle up to and including the turnaround cycle. No grant is given while busy_o=1.
- R3: With mode_i other than 1, a request gets gnt_o=0 and busy_o stays 0.
- R4: Counting from the first cycle after the grant, cycles 0..4 carry on bus_ad_o the bytes addr[23:16], addr[15:8], addr[7:0], data[15:8], data[7:0], in that order. bus_ale_o=1 in cycles 0..2 and bus_cap_o=1 in cycles 3..4. Both are 0 and bus_ad_o=0 in all other cycles.
- R5: Cycle 5 is idle (cs_no=1). Then cs_no=0 with ads_no=1 for S cycles, where S is the setup count and a count of 0 is used as 1.
- R6: The strobe phase follows with cs_no=0 and ads_no=0. If dt_ack_ni is sampled 0 in strobe cycle j, the strobe lasts j+1 cycles.
- R7: If no acknowledge arrives within P strobe cycles (P is the pulse count, 0 used as 1), the strobe ends after P cycles and err_o becomes 1 from the first hold cycle. err_o stays 1 until the next grant, which clears it.
- R8: The hold phase has cs_no=0 and ads_no=1 for H cycles (H is the hold count, 0 used as 1). It is followed by one idle cycle and one turnaround cycle, so busy_o stays 1 for 8+S+L+H cycles, where L is the strobe length.
- R9: rw_o=0 and bus_oe_no=0 exactly while cs_no=0. bus_dir_o=1 in every busy cycle except the turnaround cycle.
- R10: Changes to addr_i, data_i, setup_i, pulse_i or hold_i after the grant do not affect the access in progress.
- R11: An acknowledge sampled in the last cycle of the pulse window counts as success: the strobe lasts P cycles and err_o stays 0.
- R12: dt_ack_ni is ignored outside the strobe phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host write request |
| addr_i | input | 24 | Write address |
| data_i | input | 16 | Write data |
| mode_i | input | 2 | Protocol mode select (1 = microprocessor strobe style) |
| setup_i | input | 4 | Setup count |
| pulse_i | input | 4 | Pulse window count |
| hold_i | input | 4 | Hold count |
| gnt_o | output | 1 | Request accepted this cycle |
| busy_o | output | 1 | Access in progress |
| err_o | output | 1 | Last access timed out without acknowledge |
| bus_ad_o | output | 8 | Multiplexed address/data byte |
| bus_ale_o | output | 1 | Address latch enable pulse |
| bus_cap_o | output | 1 | Data latch capture pulse |
| bus_dir_o | output | 1 | Data latch direction, 1 toward peripheral |
| bus_oe_no | output | 1 | Data latch output enable, active low |
| cs_no | output | 1 | Chip select, active low |
| ads_no | output | 1 | Address strobe, active low |
| rw_o | output | 1 | Read/write select, 0 = write |
| dt_ack_ni | input | 1 | Data-transfer acknowledge, active low |

## Verification
The acknowledge and the end of the pulse window can fall in the same cycle. An acknowledge in the last window cycle must win over the timeout, so the strobe length is the same either way but err_o must stay 0. The bench places the acknowledge at random strobe offsets, including exactly P-1 and offsets past the window. It also drives spurious acknowledges in the setup, hold and idle cycles. For every cycle it compares strobe length, hold timing and the error flag with a cycle-by-cycle model built from the counts.

// File: rtl/sp_write_pkg.sv
package sp_write_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_GAP_A,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_GAP_B,
    ST_TURN
  } sp_state_e;
endpackage

// File: rtl/sp_phase_cnt.sv
module sp_phase_cnt #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [CW-1:0] limit_i,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == limit_i - 1'b1);
endmodule

// File: rtl/sp_byte_mux.sv
module sp_byte_mux #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned IW     = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [IW-1:0]     idx_i,
  input  logic              en_i,
  output logic [BUS_W-1:0]  ad_o,
  output logic              ale_o,
  output logic              cap_o
);
  localparam int unsigned NA = ADDR_W / BUS_W;
  localparam int unsigned ND = DATA_W / BUS_W;
  localparam int unsigned NT = NA + ND;

  logic [BUS_W-1:0] bytes [NT];

  // most significant byte first, address before data
  for (genvar g = 0; g < NA; g++) begin : g_addr
    assign bytes[g] = addr_i[ADDR_W-1-g*BUS_W -: BUS_W];
  end
  for (genvar g = 0; g < ND; g++) begin : g_data
    assign bytes[NA+g] = data_i[DATA_W-1-g*BUS_W -: BUS_W];
  end

  always_comb begin
    ad_o  = '0;
    ale_o = 1'b0;
    cap_o = 1'b0;
    for (int i = 0; i < NT; i++) begin
      if (en_i && idx_i == IW'(i)) begin
        ad_o  = bytes[i];
        ale_o = (i < NA);
        cap_o = (i >= NA);
      end
    end
  end
endmodule

// File: rtl/sp_write_fsm.sv
module sp_write_fsm
  import sp_write_pkg::*;
#(
  parameter int unsigned CW = 4,
  parameter int unsigned NT = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          ack_ni,
  input  logic          last_i,
  input  logic [CW-1:0] setup_i,
  input  logic [CW-1:0] pulse_i,
  input  logic [CW-1:0] hold_i,
  output sp_state_e     state_o,
  output logic          clr_o,
  output logic [CW-1:0] limit_o,
  output logic          err_set_o
);
  sp_state_e st_q, st_d;

  always_comb begin
    st_d      = st_q;
    err_set_o = 1'b0;
    unique case (st_q)
      ST_IDLE:   if (accept_i) st_d = ST_LOAD;
      ST_LOAD:   if (last_i) st_d = ST_GAP_A;
      ST_GAP_A:  st_d = ST_SETUP;
      ST_SETUP:  if (last_i) st_d = ST_STROBE;
      ST_STROBE: begin
        // acknowledge wins over window expiry in the same cycle
        if (!ack_ni) st_d = ST_HOLD;
        else if (last_i) begin
          st_d      = ST_HOLD;
          err_set_o = 1'b1;
        end
      end
      ST_HOLD:   if (last_i) st_d = ST_GAP_B;
      ST_GAP_B:  st_d = ST_TURN;
      ST_TURN:   st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (st_q)
      ST_LOAD:   limit_o = CW'(NT);
      ST_SETUP:  limit_o = setup_i;
      ST_STROBE: limit_o = pulse_i;
      ST_HOLD:   limit_o = hold_i;
      default:   limit_o = CW'(1);
    endcase
  end

  assign clr_o = (st_d != st_q) || (st_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/sp_write_ctrl.sv
module sp_write_ctrl
  import sp_write_pkg::*;
#(
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned BUS_W   = 8,
  parameter int unsigned TW      = 4,
  parameter int unsigned MODE_W  = 2,
  parameter int unsigned MODE_UP = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [TW-1:0]     setup_i,
  input  logic [TW-1:0]     pulse_i,
  input  logic [TW-1:0]     hold_i,
  output logic              gnt_o,
  output logic              busy_o,
  output logic              err_o,
  output logic [BUS_W-1:0]  bus_ad_o,
  output logic              bus_ale_o,
  output logic              bus_cap_o,
  output logic              bus_dir_o,
  output logic              bus_oe_no,
  output logic              cs_no,
  output logic              ads_no,
  output logic              rw_o,
  input  logic              dt_ack_ni
);
  localparam int unsigned NT     = ADDR_W / BUS_W + DATA_W / BUS_W;
  localparam int unsigned TMAX   = (1 << TW) - 1;
  localparam int unsigned MAXLIM = (TMAX > NT) ? TMAX : NT;
  localparam int unsigned CW     = $clog2(MAXLIM + 1);

  sp_state_e         state;
  logic              accept, clr, last, err_set, err_q;
  logic [CW-1:0]     limit, cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [CW-1:0]     set_q, pls_q, hld_q;

  function automatic logic [CW-1:0] eff_cnt(input logic [TW-1:0] v);
    return (v == '0) ? CW'(1) : CW'(v);
  endfunction

  assign accept = req_i && (state == ST_IDLE) && (mode_i == MODE_W'(MODE_UP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
      set_q  <= CW'(1);
      pls_q  <= CW'(1);
      hld_q  <= CW'(1);
      err_q  <= 1'b0;
    end else begin
      if (accept) begin
        addr_q <= addr_i;
        data_q <= data_i;
        set_q  <= eff_cnt(setup_i);
        pls_q  <= eff_cnt(pulse_i);
        hld_q  <= eff_cnt(hold_i);
        err_q  <= 1'b0;
      end else if (err_set) begin
        err_q  <= 1'b1;
      end
    end
  end

  sp_write_fsm #(.CW(CW), .NT(NT)) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .ack_ni    (dt_ack_ni),
    .last_i    (last),
    .setup_i   (set_q),
    .pulse_i   (pls_q),
    .hold_i    (hld_q),
    .state_o   (state),
    .clr_o     (clr),
    .limit_o   (limit),
    .err_set_o (err_set)
  );

  sp_phase_cnt #(.CW(CW)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .limit_i (limit),
    .cnt_o   (cnt),
    .last_o  (last)
  );

  sp_byte_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_W(BUS_W), .IW(CW)) i_mux (
    .addr_i (addr_q),
    .data_i (data_q),
    .idx_i  (cnt),
    .en_i   (state == ST_LOAD),
    .ad_o   (bus_ad_o),
    .ale_o  (bus_ale_o),
    .cap_o  (bus_cap_o)
  );

  logic in_cycle;
  assign in_cycle  = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);

  assign gnt_o     = accept;
  assign busy_o    = (state != ST_IDLE);
  assign err_o     = err_q;
  assign cs_no     = !in_cycle;
  assign ads_no    = (state != ST_STROBE);
  assign rw_o      = !in_cycle;
  assign bus_oe_no = !in_cycle;
  assign bus_dir_o = busy_o && (state != ST_TURN);
endmodule

// File: rtl/sp_write_chk.sv
module sp_write_chk #(
  parameter int unsigned MODE_W  = 2,
  parameter int unsigned MODE_UP = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [MODE_W-1:0] mode_i,
  input logic              gnt_o,
  input logic              busy_o,
  input logic              err_o,
  input logic              bus_ale_o,
  input logic              bus_cap_o,
  input logic              bus_oe_no,
  input logic              cs_no,
  input logic              ads_no,
  input logic              rw_o,
  input logic              dt_ack_ni
);
  AST_NO_GNT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni) busy_o |-> !gnt_o); // R2
  AST_BUSY_AFTER_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni) gnt_o |=> busy_o); // R2
  AST_GNT_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni) gnt_o |-> (mode_i == MODE_W'(MODE_UP))); // R3
  AST_LATCH_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni) !(bus_ale_o && bus_cap_o)); // R4
  AST_LATCH_IDLE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni) (bus_ale_o || bus_cap_o) |-> cs_no); // R4
  AST_ADS_IN_CS: assert property (@(posedge clk_i) disable iff (!rst_ni) !ads_no |-> !cs_no); // R6
  AST_ACK_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni) (!ads_no && !dt_ack_ni) |=> ads_no); // R6
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) (err_o && !gnt_o) |=> err_o); // R7
  AST_ERR_AT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(err_o) |-> (!cs_no && ads_no)); // R7
  AST_CS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni) !cs_no |-> busy_o); // R9
  AST_RW_OE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni) (rw_o == cs_no) && (bus_oe_no == cs_no)); // R9
endmodule

bind sp_write_ctrl sp_write_chk #(.MODE_W(MODE_W), .MODE_UP(MODE_UP)) i_sp_write_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_i    (mode_i),
  .gnt_o     (gnt_o),
  .busy_o    (busy_o),
  .err_o     (err_o),
  .bus_ale_o (bus_ale_o),
  .bus_cap_o (bus_cap_o),
  .bus_oe_no (bus_oe_no),
  .cs_no     (cs_no),
  .ads_no    (ads_no),
  .rw_o      (rw_o),
  .dt_ack_ni (dt_ack_ni)
);

// File: tb/test_sp_write_ctrl.sv
`timescale 1ns/100ps
module test_sp_write_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic [15:0] data_i = '0;
  logic [1:0]  mode_i = 2'd1;
  logic [3:0]  setup_i = '0, pulse_i = '0, hold_i = '0;
  logic        dt_ack_ni = 1'b1;
  logic        gnt_o, busy_o, err_o, bus_ale_o, bus_cap_o, bus_dir_o, bus_oe_no;
  logic        cs_no, ads_no, rw_o;
  logic [7:0]  bus_ad_o;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [23:0] lat_addr = '0;
  logic [15:0] lat_data = '0;

  sp_write_ctrl i_sp_write_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i), .data_i(data_i),
    .mode_i(mode_i), .setup_i(setup_i), .pulse_i(pulse_i), .hold_i(hold_i),
    .gnt_o(gnt_o), .busy_o(busy_o), .err_o(err_o), .bus_ad_o(bus_ad_o),
    .bus_ale_o(bus_ale_o), .bus_cap_o(bus_cap_o), .bus_dir_o(bus_dir_o),
    .bus_oe_no(bus_oe_no), .cs_no(cs_no), .ads_no(ads_no), .rw_o(rw_o),
    .dt_ack_ni(dt_ack_ni)
  );

  always #2.5 clk_i = ~clk_i;

  // external latch model
  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (bus_ale_o) lat_addr <= {lat_addr[15:0], bus_ad_o};
    if (bus_cap_o) lat_data <= {lat_data[7:0], bus_ad_o};
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    wait (cyc > 150000);
    n_bad++;
    $display("FAIL watchdog: actual run still going, expected finished");
    summary();
  end

  // packed view: busy cs ads rw oe dir ale cap err gnt ad
  function automatic logic [17:0] pack_obs();
    return {busy_o, cs_no, ads_no, rw_o, bus_oe_no, bus_dir_o, bus_ale_o, bus_cap_o,
            err_o, gnt_o, bus_ad_o};
  endfunction

  task automatic cmp(input logic [17:0] exp_v, input string tag);
    logic [17:0] act;
    act = pack_obs();
    n_vec++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic cmp_val(input logic [31:0] act, input logic [31:0] exp_v, input string tag);
    n_vec++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  function automatic int eff(input logic [3:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  function automatic logic [17:0] idle_vec(input logic err, input logic gnt);
    return {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, err, gnt, 8'h00};
  endfunction

  logic err_model = 1'b0;

  task automatic run_txn(input logic [23:0] a, input logic [15:0] d,
                         input logic [3:0] s, input logic [3:0] p, input logic [3:0] h,
                         input int ack_at, input bit noise, input bit keep_req);
    int se, pe, he, len, tot, st_set, st_stb, st_hld;
    bit exp_err;
    se = eff(s); pe = eff(p); he = eff(h);
    len = (ack_at < pe) ? ack_at + 1 : pe;
    exp_err = (ack_at >= pe);
    tot = 8 + se + len + he;
    st_set = 6; st_stb = 6 + se; st_hld = st_stb + len;
    @(negedge clk_i);
    req_i = 1'b1; addr_i = a; data_i = d; setup_i = s; pulse_i = p; hold_i = h;
    mode_i = 2'd1; dt_ack_ni = 1'b1;
    #1 cmp(idle_vec(err_model, 1'b1), "R2 grant");
    for (int k = 0; k <= tot; k++) begin
      logic [17:0] e;
      logic [7:0]  byte_e;
      string tag;
      bit stb;
      @(negedge clk_i);
      if (k == 0) begin
        if (!keep_req) req_i = 1'b0;
        // R10: disturb captured inputs
        addr_i = 24'($urandom); data_i = 16'($urandom);
        setup_i = 4'($urandom); pulse_i = 4'($urandom); hold_i = 4'($urandom);
      end
      if (keep_req && k == tot - 1) req_i = 1'b0;
      stb = (k >= st_stb) && (k < st_hld);
      if (stb) dt_ack_ni = (k - st_stb == ack_at) ? 1'b0 : 1'b1;
      else     dt_ack_ni = noise ? 1'($urandom) : 1'b1; // R12
      #1;
      byte_e = 8'h00;
      if (k < 3)       byte_e = 8'(a >> (8 * (2 - k)));
      else if (k == 3) byte_e = d[15:8];
      else if (k == 4) byte_e = d[7:0];
      if (k >= st_hld) err_model = exp_err;
      else             err_model = 1'b0;
      if (k == tot) begin
        e = idle_vec(err_model, 1'b0); tag = "R8 end";
      end else begin
        logic cyc_on;
        cyc_on = (k >= st_set) && (k < tot - 2);
        e = {1'b1, !cyc_on, !stb, !cyc_on, !cyc_on, (k != tot - 1),
             (k < 3), (k >= 3 && k < 5), err_model, 1'b0, byte_e};
        if (k < 5)            tag = "R4 bytes";
        else if (k < st_stb)  tag = "R5 setup";
        else if (stb)         tag = exp_err ? "R7 window" : (ack_at == pe - 1 ? "R11 late ack" : "R6 strobe");
        else                  tag = "R8 hold";
      end
      cmp(e, tag);
    end
    dt_ack_ni = 1'b1;
    cmp_val(32'(lat_addr), 32'(a), "R4 latched addr R10");
    cmp_val(32'(lat_data), 32'(d), "R4 latched data R10");
  endtask

  task automatic try_bad_mode(input logic [1:0] m);
    @(negedge clk_i);
    req_i = 1'b1; mode_i = m;
    #1 cmp(idle_vec(err_model, 1'b0), "R3 no grant");
    @(negedge clk_i);
    #1 cmp(idle_vec(err_model, 1'b0), "R3 stays idle");
    req_i = 1'b0; mode_i = 2'd1;
  endtask

  initial begin
    void'($urandom(32'h5EED_0017));
    repeat (3) @(negedge clk_i);
    #1 cmp(idle_vec(1'b0, 1'b0), "R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1 cmp(idle_vec(1'b0, 1'b0), "R1 after reset");

    // directed corners
    run_txn(24'hA1B2C3, 16'hD4E5, 4'd7, 4'd5, 4'd1, 2, 1'b0, 1'b0);   // R6
    run_txn(24'h123456, 16'h789A, 4'd3, 4'd5, 4'd2, 4, 1'b1, 1'b0);   // R11
    run_txn(24'hFFFFFF, 16'h0000, 4'd2, 4'd4, 4'd3, 99, 1'b0, 1'b0);  // R7
    try_bad_mode(2'd0);                                                // R3, err kept R7
    run_txn(24'h000001, 16'h8001, 4'd0, 4'd0, 4'd0, 0, 1'b1, 1'b1);   // zero counts R5 R8, R2 req held
    run_txn(24'h5A5A5A, 16'hA5A5, 4'd0, 4'd0, 4'd0, 99, 1'b0, 1'b0);  // R7 P=1 timeout
    try_bad_mode(2'd2);
    try_bad_mode(2'd3);
    run_txn(24'hC0FFEE, 16'hBEEF, 4'd15, 4'd15, 4'd15, 14, 1'b1, 1'b0); // R11 max

    for (int t = 0; t < 60; t++) begin
      logic [3:0] s, p, h;
      int ack;
      s = 4'($urandom); p = 4'($urandom); h = 4'($urandom);
      ack = int'($urandom % (eff(p) + 3));
      run_txn(24'($urandom), 16'($urandom), s, p, h, ack, 1'($urandom), 1'($urandom));
      if (($urandom % 8) == 0) try_bad_mode(($urandom % 2) ? 2'd0 : 2'd2);
    end
    summary();
  end
endmodule